// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers hardware events from a set of peripherals and turns them into a single vectored request towards a processor. Each peripheral owns a group of event sources. Each source has a sticky flag and its own mask bit. The masked flags of a group are ORed into one request line for that peripheral. A per-peripheral enable then gates that line. This gives fine control over individual sources and coarse control over whole peripherals.

A fixed-priority arbiter picks among the enabled peripheral requests, and the lowest peripheral index wins. The winner is presented as an exception number, with peripheral 0 mapped to exception 16. The block also presents the byte address of that exception's 32-bit vector entry, computed as the table base plus four times the exception number. The table base comes from a programmable register. Software sets masks, enables and the base, and clears flags, through a simple write port and a combinational read port. The processor side sees a valid/acknowledge handshake.

Top module: `irq_two_level_ctrl`

## Requirements
- R1: A one-cycle pulse on a source input sets that source's flag on the next clock edge. The flag then stays set until it is cleared.
- R2: Writing to clear address 2+NPERIPH+p clears each flag of peripheral p whose bit in the write data is 1. If a pulse and a clear hit the same flag in the same cycle, the flag ends up set.
- R3: The request line of peripheral p is active when its enable (bit p at address 1) is 1 and at least one of its flags is 1 with the matching mask bit (address 2+p) also 1.
- R4: When several requests are active, the lowest peripheral index wins, and the exception number presented is 16 plus that index.
- R5: The vector address output equals the table base plus four times the presented exception number.
- R6: While valid is high and acknowledge is low, valid and the exception number hold their values. In any cycle where valid is low or acknowledge is high, the next clock edge loads the current arbitration result.
- R7: When no request is selected, valid is 0, the exception number is 0 and the vector address equals the table base.
- R8: The table base register (address 0) reads back with bits 6:0 forced to zero.
- R9: After reset, all flags, masks, enables and the table base read as zero, and valid is low.
- R10: The read port returns the base at address 0, the enables at address 1, the mask of peripheral p at address 2+p, and the flags of peripheral p at address 2+NPERIPH+p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | NPERIPH*NSRC | Event pulses; bit p*NSRC+s is source s of peripheral p |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| irq_valid | output | 1 | A selected exception is presented |
| irq_num | output | EXC_W | Presented exception number, 0 when idle |
| irq_vec_addr | output | 32 | Byte address of the presented vector entry |
| irq_ack | input | 1 | Processor accepts the presented exception |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that the processor raises acknowledge only while valid is high, although an acknowledge at any other time is harmless. Source pulses may arrive on any cycle and on many sources at once. Writes may go to any address, including ones that are not decoded. The random stimulus keeps write addresses inside the decoded range most of the time. It raises acknowledge only alongside valid. It keeps pulses sparse, so that flags build up and drain through clears, and the arbiter sees both single and competing requests.

// File: rtl/irq_two_level_ctrl.sv
module irq_two_level_ctrl #(
  parameter int NPERIPH   = 17,
  parameter int NSRC      = 8,
  parameter int FIRST_EXC = 16,
  parameter int EXC_W     = $clog2(FIRST_EXC + NPERIPH),
  parameter int AW        = $clog2(2 + 2 * NPERIPH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPERIPH*NSRC-1:0] src_pulse,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [31:0]             wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [31:0]             rd_data,
  output logic                    irq_valid,
  output logic [EXC_W-1:0]        irq_num,
  output logic [31:0]             irq_vec_addr,
  input  logic                    irq_ack
);
  localparam int NBITS    = NPERIPH * NSRC;
  localparam int A_BASE   = 0;
  localparam int A_EN     = 1;
  localparam int A_MASK0  = 2;
  localparam int A_CLR0   = 2 + NPERIPH;

  logic [NBITS-1:0]   flag_q, mask_q, clr_vec;
  logic [NPERIPH-1:0] en_q, top_req;
  logic [31:0]        base_q;
  logic               win_any;
  logic [EXC_W-1:0]   win_num;

  for (genvar p = 0; p < NPERIPH; p++) begin : g_per
    assign clr_vec[p*NSRC +: NSRC] =
      (wr_en && wr_addr == AW'(A_CLR0 + p)) ? wr_data[NSRC-1:0] : '0;
    assign top_req[p] = en_q[p] & |(flag_q[p*NSRC +: NSRC] & mask_q[p*NSRC +: NSRC]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
      en_q   <= '0;
      base_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_vec) | src_pulse;
      if (wr_en) begin
        if (wr_addr == AW'(A_BASE)) base_q <= {wr_data[31:7], 7'b0};
        if (wr_addr == AW'(A_EN))   en_q   <= wr_data[NPERIPH-1:0];
        for (int p = 0; p < NPERIPH; p++)
          if (wr_addr == AW'(A_MASK0 + p)) mask_q[p*NSRC +: NSRC] <= wr_data[NSRC-1:0];
      end
    end
  end

  always_comb begin
    win_any = 1'b0;
    win_num = '0;
    for (int p = NPERIPH - 1; p >= 0; p--)
      if (top_req[p]) begin
        win_any = 1'b1;
        win_num = EXC_W'(FIRST_EXC + p);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_num   <= '0;
    end else if (!irq_valid || irq_ack) begin
      irq_valid <= win_any;
      irq_num   <= win_num;
    end
  end

  assign irq_vec_addr = base_q + (32'(irq_num) << 2);

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_BASE)) rd_data = base_q;
    if (rd_addr == AW'(A_EN))   rd_data[NPERIPH-1:0] = en_q;
    for (int p = 0; p < NPERIPH; p++) begin
      if (rd_addr == AW'(A_MASK0 + p)) rd_data[NSRC-1:0] = mask_q[p*NSRC +: NSRC];
      if (rd_addr == AW'(A_CLR0 + p))  rd_data[NSRC-1:0] = flag_q[p*NSRC +: NSRC];
    end
  end

  // R1
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_pulse) & ~flag_q) == '0);
  // R1 R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q) & ~$past(clr_vec) & ~flag_q) == '0);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_num)));
  // R3 R6
  rearb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid || irq_ack) |=> (irq_valid == $past(|top_req)));
  // R7
  idle_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_num == '0 && irq_vec_addr == base_q));
  // R8
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[6:0] == 7'b0);
endmodule

// File: tb/tb_irq_two_level_ctrl.sv
module tb_irq_two_level_ctrl;
  localparam int PERIOD = 10;
  localparam int NP = 17, NS = 8, NB = NP * NS, AW = 6, EW = 6;

  logic clk = 0, rst_n = 0;
  logic [NB-1:0] src_pulse = '0;
  logic wr_en = 0, irq_ack = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data, irq_vec_addr;
  logic irq_valid;
  logic [EW-1:0] irq_num;

  irq_two_level_ctrl dut (.clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_valid(irq_valid), .irq_num(irq_num),
    .irq_vec_addr(irq_vec_addr), .irq_ack(irq_ack));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [NB-1:0] mflag = '0, mmask = '0;
  logic [NP-1:0] men = '0;
  logic [31:0] mbase = '0;
  logic mv = 0;
  logic [EW-1:0] mn = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int arb();
    for (int p = 0; p < NP; p++)
      if (men[p] && |(mflag[p*NS +: NS] & mmask[p*NS +: NS])) return p;
    return -1;
  endfunction

  function automatic logic [31:0] rd_exp(logic [AW-1:0] a);
    logic [31:0] r = '0;
    if (a == 0) r = mbase;
    else if (a == 1) r[NP-1:0] = men;
    else if (a < 2 + NP) r[NS-1:0] = mmask[(a-2)*NS +: NS];
    else if (a < 2 + 2*NP) r[NS-1:0] = mflag[(a-2-NP)*NS +: NS];
    return r;
  endfunction

  task automatic step(logic [NB-1:0] pl, logic we, logic [AW-1:0] wa,
                      logic [31:0] wd, logic ak, logic [AW-1:0] ra);
    int w;
    logic [NB-1:0] clr;
    src_pulse = pl; wr_en = we; wr_addr = wa; wr_data = wd; irq_ack = ak; rd_addr = ra;
    @(posedge clk);
    w = arb();
    if (!mv || ak) begin
      mv = (w >= 0);
      mn = (w >= 0) ? EW'(16 + w) : '0;
    end
    clr = '0;
    if (we && wa >= 2 + NP && wa < 2 + 2*NP) clr[(wa-2-NP)*NS +: NS] = wd[NS-1:0];
    mflag = (mflag & ~clr) | pl;
    if (we) begin
      if (wa == 0) mbase = {wd[31:7], 7'b0};
      else if (wa == 1) men = wd[NP-1:0];
      else if (wa < 2 + NP) mmask[(wa-2)*NS +: NS] = wd[NS-1:0];
    end
    #1;
    chk("R6 valid", 32'(irq_valid), 32'(mv));
    chk("R4 R6 R7 number", 32'(irq_num), 32'(mn));
    chk("R5 vector", irq_vec_addr, mbase + 32'(mn) * 4);
    chk("R10 read", rd_data, rd_exp(ra));
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9 reset state
    chk("R9 valid", 32'(irq_valid), 0);
    for (int a = 0; a < 2 + 2*NP; a++) begin
      rd_addr = AW'(a); #1;
      chk("R9 reset regs", rd_data, 0);
    end
    // R8 base alignment
    step('0, 1, 0, 32'hFFFF_FFFF, 0, 0);
    chk("R8 base", rd_data, 32'hFFFF_FF80);
    step('0, 1, 0, 32'h0001_2345, 0, 0);
    chk("R8 base2", rd_data, 32'h0001_2300);
    // R1 flag set with masks and enables off: no request (R3)
    step(NB'(1) << (5*NS+2), 0, 0, 0, 0, AW'(2+NP+5));
    step('0, 0, 0, 0, 0, AW'(2+NP+5));
    chk("R1 flag sticky", rd_data, 32'h4);
    chk("R3 masked no request", 32'(irq_valid), 0);
    // R3 enable and mask peripherals 3 and 5
    step('0, 1, 1, 32'h28, 0, 0);
    step('0, 1, AW'(2+5), 32'h4, 0, 0);
    step('0, 0, 0, 0, 0, 0);
    chk("R3 p5 request", 32'(irq_num), 21);
    // R4 add peripheral 3, lower index wins after ack
    step(NB'(1) << (3*NS), 1, AW'(2+3), 32'h1, 0, 0);
    step('0, 0, 0, 0, 0, 0);
    chk("R6 hold p5", 32'(irq_num), 21);
    step('0, 0, 0, 0, 1, 0);
    chk("R4 priority p3", 32'(irq_num), 19);
    chk("R5 vector p3", irq_vec_addr, 32'h0001_2300 + 19*4);
    // R2 set wins over clear on the same flag
    step(NB'(1) << (3*NS), 1, AW'(2+NP+3), 32'h1, 0, AW'(2+NP+3));
    chk("R2 set wins", rd_data, 32'h1);
    step('0, 1, AW'(2+NP+3), 32'h1, 0, AW'(2+NP+3));
    chk("R2 cleared", rd_data, 32'h0);
    step('0, 1, AW'(2+NP+5), 32'h4, 1, 0);
    step('0, 0, 0, 0, 1, 0);
    chk("R7 idle number", 32'(irq_num), 0);
    chk("R7 idle vector", irq_vec_addr, 32'h0001_2300);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [NB-1:0] pl;
      logic we, ak;
      logic [AW-1:0] wa;
      logic [31:0] wd;
      for (int b = 0; b < NB; b++) pl[b] = ($urandom % 64) == 0;
      we = ($urandom % 3) == 0;
      wa = AW'($urandom % (2 + 2*NP + 2));
      wd = $urandom;
      if (wa >= 2 + NP && ($urandom % 2)) wd = 32'hFF;
      ak = irq_valid && ($urandom % 2);
      step(pl, we, wa, wd, ak, AW'($urandom % (2 + 2*NP)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule